// File: doc/BRIEF.md
# Time-Slotted Serial Chain Link Controller

This block is the controller end of a serial link that serves a chain of up to eight slave devices over one shared bidirectional data line. Each transfer is a frame. The controller opens a frame by pulling its active-low frame strobe low for one bit period. After that it runs a shift clock through a fixed number of time slots, and each slot carries one byte for one slave, least significant bit first. A separate output tags every frame as a command frame or a data frame. Two direction indicators tell the slaves and any line buffers whether the controller is driving the data line (write) or listening on it (read).

A host starts a frame with a one-cycle `start` pulse. Along with the pulse it gives the frame kind, the direction and, for writes, the packed bytes for all slots. The frame ends with a one-cycle `done` pulse. For reads, the captured bytes are then present on `rx_data`. The slaves share an open-collector, active-low fault input. A fault sampled during a frame sets a sticky status bit, and the frame then stops at the end of the slot in progress.

Top module: `sslk_link`

## Requirements
- R1: While and after reset, and before the first frame: `frm_n`=1, `bit_clk`=1, `sdl_oe`=0, `sdl_o`=0, `dir_out_n`=1, `sense_n`=1, `kind_cmd`=0, `busy`=0, `done`=0 and `err_stat`=0.
- R2: Every frame starts with `frm_n` low for exactly 2*SCLK_HALF clock cycles. `kind_cmd` is 1 for a command frame (`frame_cmd`=1) and 0 for a data frame. It is steady through the frame and returns to 0 one cycle after `done`.
- R3: In the cycle in which `frm_n` returns high, `bit_clk` goes low. The shift clock then runs one period per bit: SCLK_HALF cycles low, then SCLK_HALF cycles high. A frame without a fault has SLOTS*BITS periods. `bit_clk` stays high while `frm_n` is low and while idle.
- R4: In a write frame (`frame_rd`=0), bit b of slot s is driven on `sdl_o` during falling edge number s*BITS+b+1 of the shift clock, and it equals `tx_data[s*BITS+b]`. So slot 0 comes first, LSB first. `sdl_o` changes only when `bit_clk` falls and is stable while it is high.
- R5: In a read frame (`frame_rd`=1), `rx_data[s*BITS+b]` is the value of `sdl_i` at the rising edge of `bit_clk` for bit b of slot s. `rx_data` is valid when `done` is high.
- R6: `sdl_oe` is 1 only during the shift phase of write frames, and `dir_out_n` is low exactly when `sdl_oe` is 1.
- R7: `sense_n` is low only during the shift phase of read frames. It is never low while `sdl_oe` is 1.
- R8: If `fault_n` is sampled low during a frame, `err_stat` is set and the frame ends after the slot in progress completes. A fault in slot k gives 8*(k+1) shift periods, and a fault during the frame strobe stops the frame after slot 0. Bits of slots not reached read back as 0 on `rx_data`.
- R9: `err_stat` stays set after the frame ends and is cleared only when the next start is accepted. A low `fault_n` while idle does not set it.
- R10: A `start` pulse while `busy`=1 is ignored. The frame in progress keeps its kind, its data and its length, and it gives exactly one `done`.
- R11: `done` is a one-cycle pulse at the end of each frame, and `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a frame when idle |
| frame_cmd | input | 1 | 1 = command frame, 0 = data frame |
| frame_rd | input | 1 | 1 = read frame, 0 = write frame |
| tx_data | input | SLOTS*BITS | Write bytes, slot s in bits [s*BITS +: BITS] |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | SLOTS*BITS | Read bytes, same packing as tx_data |
| err_stat | output | 1 | Sticky fault status |
| sdl_i | input | 1 | Serial data line, input side |
| sdl_o | output | 1 | Serial data line, output value |
| sdl_oe | output | 1 | Serial data line output enable |
| dir_out_n | output | 1 | Active-low: data line driven as output |
| frm_n | output | 1 | Active-low frame strobe |
| kind_cmd | output | 1 | Frame kind tag: 1 command, 0 data |
| bit_clk | output | 1 | Shift clock |
| sense_n | output | 1 | Active-low: read mode, line being sampled |
| fault_n | input | 1 | Shared active-low fault from slaves |

## Verification
The bench injects faults in the middle of slot 2, during the frame strobe and in the last slot, and compares the count of shift-clock falls and the zeroed upper bytes. A design that stopped at once, or a whole slot late, would give the wrong count and show bits it should not have. It checks that the status stays set after a faulted frame, is cleared by the next start and ignores faults while idle. A design that cleared the status at `done`, or sampled the fault while idle, would fail there. A second `start` in the middle of a frame, with a different kind and different data, catches a design that restarts or changes the frame kind while it runs. Pin-level tracking of strobe width, of shift-clock low phases and of direction flags catches off-by-one framing and bits written on the wrong edge.

// File: rtl/sslk_pkg.sv
package sslk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_SHIFT = 2'd2
  } link_state_t;
endpackage

// File: rtl/sslk_phase_gen.sv
// Bit-period timer: SCLK_HALF cycles low phase, SCLK_HALF cycles high phase.
module sslk_phase_gen #(
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic low_half,
  output logic rise_tick,
  output logic period_end
);
  localparam int PER = 2 * SCLK_HALF;
  localparam int CW  = (PER > 1) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(PER - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign low_half   = (cnt < CW'(SCLK_HALF));
  // the registered clock pin turns high on the edge where cnt == SCLK_HALF
  assign rise_tick  = run && (cnt == CW'(SCLK_HALF));
  assign period_end = run && (cnt == CW'(PER - 1));
endmodule

// File: rtl/sslk_lanes.sv
// Per-slot byte lanes: transmit storage and receive capture.
module sslk_lanes #(
  parameter int SLOTS = 8,
  parameter int BITS  = 8,
  parameter int SW    = 3,
  parameter int BW    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [SLOTS*BITS-1:0] tx_in,
  input  logic [SW-1:0]         slot_idx,
  input  logic [BW-1:0]         bit_idx,
  input  logic                  capture,
  input  logic                  rx_bit,
  output logic                  tx_bit,
  output logic [SLOTS*BITS-1:0] rx_out
);
  localparam int W  = SLOTS * BITS;
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  tx_all;
  logic [IW-1:0] flat;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    logic [BITS-1:0] tx_r;
    logic [BITS-1:0] rx_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        tx_r <= '0;
        rx_r <= '0;
      end else if (load) begin
        tx_r <= tx_in[g*BITS +: BITS];
        rx_r <= '0;
      end else if (capture && (slot_idx == SW'(g))) begin
        rx_r[bit_idx] <= rx_bit;
      end
    end

    assign tx_all[g*BITS +: BITS] = tx_r;
    assign rx_out[g*BITS +: BITS] = rx_r;
  end

  assign flat   = IW'(slot_idx) * IW'(BITS) + IW'(bit_idx);
  assign tx_bit = tx_all[flat];
endmodule

// File: rtl/sslk_err_mon.sv
// Samples the shared fault line and keeps a sticky status flag.
module sslk_err_mon (
  input  logic clk,
  input  logic rst,
  input  logic fault_n,
  input  logic in_frame,
  input  logic clear,
  output logic err_flag
);
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      fault_q <= !fault_n;
      if (clear) begin
        err_flag <= 1'b0;
      end else if (in_frame && fault_q) begin
        err_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sslk_link.sv
module sslk_link #(
  parameter int SLOTS     = 8,
  parameter int BITS      = 8,
  parameter int SCLK_HALF = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  frame_cmd,
  input  logic                  frame_rd,
  input  logic [SLOTS*BITS-1:0] tx_data,
  output logic                  busy,
  output logic                  done,
  output logic [SLOTS*BITS-1:0] rx_data,
  output logic                  err_stat,
  input  logic                  sdl_i,
  output logic                  sdl_o,
  output logic                  sdl_oe,
  output logic                  dir_out_n,
  output logic                  frm_n,
  output logic                  kind_cmd,
  output logic                  bit_clk,
  output logic                  sense_n,
  input  logic                  fault_n
);
  import sslk_pkg::*;

  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  link_state_t   state;
  logic [SW-1:0] slot_idx;
  logic [BW-1:0] bit_idx;
  logic          cmd_q;
  logic          rd_q;
  logic          accept;
  logic          low_half;
  logic          rise_tick;
  logic          period_end;
  logic          tx_bit;
  logic          capture;
  logic          last_bit;
  logic          last_slot;
  logic          shifting;

  assign accept    = start && (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign shifting  = (state == ST_SHIFT);
  assign last_bit  = (bit_idx == BW'(BITS - 1));
  assign last_slot = (slot_idx == SW'(SLOTS - 1));
  assign capture   = shifting && rise_tick && rd_q;

  sslk_phase_gen #(.SCLK_HALF(SCLK_HALF)) phase_i (
    .clk        (clk),
    .rst        (rst),
    .run        (busy),
    .low_half   (low_half),
    .rise_tick  (rise_tick),
    .period_end (period_end)
  );

  sslk_lanes #(.SLOTS(SLOTS), .BITS(BITS), .SW(SW), .BW(BW)) lanes_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .tx_in    (tx_data),
    .slot_idx (slot_idx),
    .bit_idx  (bit_idx),
    .capture  (capture),
    .rx_bit   (sdl_i),
    .tx_bit   (tx_bit),
    .rx_out   (rx_data)
  );

  sslk_err_mon err_i (
    .clk      (clk),
    .rst      (rst),
    .fault_n  (fault_n),
    .in_frame (busy),
    .clear    (accept),
    .err_flag (err_stat)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slot_idx <= '0;
      bit_idx  <= '0;
      cmd_q    <= 1'b0;
      rd_q     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_FRAME;
            cmd_q    <= frame_cmd;
            rd_q     <= frame_rd;
            slot_idx <= '0;
            bit_idx  <= '0;
          end
        end
        ST_FRAME: begin
          if (period_end) begin
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (period_end) begin
            if (last_bit) begin
              bit_idx <= '0;
              if (last_slot || err_stat) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                slot_idx <= slot_idx + 1'b1;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered link pins, all one cycle behind the sequencer state
  always_ff @(posedge clk) begin
    if (rst) begin
      frm_n     <= 1'b1;
      bit_clk   <= 1'b1;
      sdl_o     <= 1'b0;
      sdl_oe    <= 1'b0;
      dir_out_n <= 1'b1;
      sense_n   <= 1'b1;
      kind_cmd  <= 1'b0;
    end else begin
      frm_n     <= (state != ST_FRAME);
      bit_clk   <= !(shifting && low_half);
      sdl_oe    <= shifting && !rd_q;
      dir_out_n <= !(shifting && !rd_q);
      sdl_o     <= (shifting && !rd_q) ? tx_bit : 1'b0;
      sense_n   <= !(shifting && rd_q);
      kind_cmd  <= busy && cmd_q;
    end
  end
endmodule

// File: rtl/sslk_link_chk.sv
module sslk_link_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err_stat,
  input logic sdl_o,
  input logic sdl_oe,
  input logic dir_out_n,
  input logic frm_n,
  input logic kind_cmd,
  input logic bit_clk,
  input logic sense_n
);
  a_r3_clk_high_in_strobe: assert property (@(posedge clk) disable iff (rst)
    !frm_n |-> bit_clk);

  a_r6_dir_follows_drive: assert property (@(posedge clk) disable iff (rst)
    sdl_oe |-> !dir_out_n);

  a_r7_sense_not_driving: assert property (@(posedge clk) disable iff (rst)
    !sense_n |-> !sdl_oe);

  a_r2_kind_steady: assert property (@(posedge clk) disable iff (rst)
    (!frm_n && $past(!frm_n)) |-> $stable(kind_cmd));

  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    (bit_clk && $past(bit_clk) && sdl_oe && $past(sdl_oe)) |-> $stable(sdl_o));

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_stat && !(start && !busy)) |=> err_stat);
endmodule

bind sslk_link sslk_link_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err_stat  (err_stat),
  .sdl_o     (sdl_o),
  .sdl_oe    (sdl_oe),
  .dir_out_n (dir_out_n),
  .frm_n     (frm_n),
  .kind_cmd  (kind_cmd),
  .bit_clk   (bit_clk),
  .sense_n   (sense_n)
);

// File: tb/sslk_link_tb_top.sv
`timescale 1ns/1ps
module sslk_link_tb_top;
  localparam int SLOTS = 8;
  localparam int BITS  = 8;
  localparam int HALF  = 2;
  localparam int W     = SLOTS * BITS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         frame_cmd = 1'b0;
  logic         frame_rd = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         busy, done, err_stat;
  logic [W-1:0] rx_data;
  logic         sdl_i = 1'b0;
  logic         sdl_o, sdl_oe, dir_out_n, frm_n, kind_cmd, bit_clk, sense_n;
  logic         fault_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sslk_link #(.SLOTS(SLOTS), .BITS(BITS), .SCLK_HALF(HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .frame_cmd(frame_cmd),
    .frame_rd(frame_rd), .tx_data(tx_data), .busy(busy), .done(done),
    .rx_data(rx_data), .err_stat(err_stat), .sdl_i(sdl_i), .sdl_o(sdl_o),
    .sdl_oe(sdl_oe), .dir_out_n(dir_out_n), .frm_n(frm_n),
    .kind_cmd(kind_cmd), .bit_clk(bit_clk), .sense_n(sense_n),
    .fault_n(fault_n)
  );

  typedef struct {
    int           falls;
    logic [W-1:0] rx;
    logic [W-1:0] tx;
    logic         err;
    logic         cmd;
    logic         rd;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // slave model state
  bit           cur_rd = 0;
  logic [W-1:0] rd_pat = '0;
  logic [W-1:0] wr_cap = '0;
  int           fall_cnt = 0;
  int           fault_fall = -1;
  bit           fault_strobe = 0;
  int           fault_timer = 0;

  always @(negedge frm_n) begin
    fall_cnt = 0;
    wr_cap   = '0;
    if (fault_strobe) begin
      fault_n     = 1'b0;
      fault_timer = 3;
    end
  end

  always @(negedge bit_clk) begin
    fall_cnt = fall_cnt + 1;
    if (cur_rd && fall_cnt <= W) sdl_i = rd_pat[fall_cnt-1];
    if (fault_fall >= 0 && fall_cnt == fault_fall) begin
      fault_n     = 1'b0;
      fault_timer = 3;
    end
  end

  always @(posedge bit_clk) begin
    if (fall_cnt > 0 && fall_cnt <= W && sdl_oe) wr_cap[fall_cnt-1] = sdl_o;
  end

  always @(negedge clk) begin
    if (fault_timer > 0) begin
      fault_timer = fault_timer - 1;
      if (fault_timer == 0) fault_n = 1'b1;
    end
  end

  // pin monitor and scoreboard
  int   strobe_len = 0;
  logic kind_seen = 1'b0;
  bit   bad3 = 0, bad6 = 0, bad7 = 0;
  logic prev_frm = 1'b1;
  int   low_len = 0;
  bit   post_done = 0;
  exp_t last_e;

  always @(negedge clk) begin
    if (!rst) begin
      if (post_done) begin
        post_done = 0;
        check(done == 1'b0, "R11 done lasts one cycle", W'(done), '0);
        check(kind_cmd == 1'b0, "R2 kind_cmd back to 0", W'(kind_cmd), '0);
        check(err_stat == last_e.err, "R9 status after frame",
              W'(err_stat), W'(last_e.err));
      end
      if (!frm_n) begin
        strobe_len++;
        kind_seen = kind_cmd;
      end
      if (prev_frm == 1'b0 && frm_n == 1'b1 && bit_clk != 1'b0) bad3 = 1;
      prev_frm = frm_n;
      if (bit_clk == 1'b0) low_len++;
      else begin
        if (low_len != 0 && low_len != HALF) bad3 = 1;
        low_len = 0;
      end
      if (dir_out_n == sdl_oe) bad6 = 1;
      if (sdl_oe && cur_rd) bad6 = 1;
      if (!sense_n && (!cur_rd || sdl_oe)) bad7 = 1;
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected extra done", W'(1), W'(0));
        end else begin
          exp_t e;
          logic [W-1:0] mask;
          e = exp_q.pop_front();
          last_e = e;
          mask = (e.falls >= W) ? '1 : ((W'(1) << e.falls) - W'(1));
          check(strobe_len == 2*HALF, "R2 strobe width", W'(strobe_len), W'(2*HALF));
          check(kind_seen == e.cmd, "R2 kind during strobe", W'(kind_seen), W'(e.cmd));
          check(fall_cnt == e.falls, e.err ? "R8 periods before stop" : "R3 period count",
                W'(fall_cnt), W'(e.falls));
          check(!bad3, "R3 clock phase timing", W'(bad3), '0);
          check(!bad6, "R6 drive direction flags", W'(bad6), '0);
          check(!bad7, "R7 sense flag", W'(bad7), '0);
          check(busy == 1'b0, "R11 idle at done", W'(busy), '0);
          check(err_stat == e.err, "R8 fault status at done", W'(err_stat), W'(e.err));
          if (e.rd)
            check(rx_data == e.rx, e.err ? "R8 read data with stop" : "R5 read data",
                  rx_data, e.rx);
          else
            check((wr_cap & mask) == (e.tx & mask), "R4 written bits",
                  wr_cap & mask, e.tx & mask);
          if (!e.rd) check(rx_data == '0, "R8 unreached rx lanes zero", rx_data, '0);
        end
        strobe_len = 0;
        bad3 = 0; bad6 = 0; bad7 = 0;
        post_done = 1;
      end
    end
  end

  // driver: fslot = -1 none, 8 = during strobe, else slot index
  task automatic run_frame(input bit cmd, input bit rd, input logic [W-1:0] tx,
                           input logic [W-1:0] pat, input int fslot, input bit poke);
    exp_t e;
    int   slots;
    logic [W-1:0] mask;
    slots = (fslot < 0) ? SLOTS : ((fslot >= SLOTS) ? 1 : fslot + 1);
    e.falls = slots * BITS;
    mask = (e.falls >= W) ? '1 : ((W'(1) << e.falls) - W'(1));
    e.rx  = rd ? (pat & mask) : '0;
    e.tx  = tx;
    e.err = (fslot >= 0);
    e.cmd = cmd;
    e.rd  = rd;
    exp_q.push_back(e);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    cur_rd       = rd;
    rd_pat       = pat;
    fault_strobe = (fslot >= SLOTS);
    fault_fall   = (fslot >= 0 && fslot < SLOTS) ? fslot * BITS + 4 : -1;
    frame_cmd = cmd; frame_rd = rd; tx_data = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0; frame_cmd = ~cmd; frame_rd = ~rd; tx_data = ~tx;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    fault_strobe = 0;
    fault_fall   = -1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check({frm_n, bit_clk, sdl_oe, sdl_o, dir_out_n, sense_n, kind_cmd, busy, done, err_stat}
          == 10'b1100110000, "R1 reset outputs",
          W'({frm_n, bit_clk, sdl_oe, sdl_o, dir_out_n, sense_n, kind_cmd, busy, done, err_stat}),
          W'(10'b1100110000));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({frm_n, bit_clk, sdl_oe, dir_out_n, sense_n, busy, err_stat} == 7'b1101100,
          "R1 idle outputs after reset",
          W'({frm_n, bit_clk, sdl_oe, dir_out_n, sense_n, busy, err_stat}), W'(7'b1101100));

    run_frame(1, 0, 64'hA5C3_0F1E_8877_0102, '0, -1, 0);   // R4 command write
    run_frame(0, 1, '0, 64'h1234_5678_9ABC_DEF0, -1, 0);   // R5 data read
    run_frame(0, 0, 64'hFFFF_0000_AAAA_5555, '0, -1, 0);   // R4 data write
    run_frame(1, 1, '0, 64'h8000_0000_0000_0001, -1, 0);   // R5 command read

    // R9 idle fault has no effect
    @(negedge clk);
    fault_n = 1'b0;
    repeat (4) @(negedge clk);
    fault_n = 1'b1;
    repeat (4) @(negedge clk);
    check(err_stat == 1'b0, "R9 idle fault ignored", W'(err_stat), '0);

    run_frame(0, 1, '0, 64'hDEAD_BEEF_CAFE_F00D, 2, 0);    // R8 fault mid slot 2
    repeat (20) @(negedge clk);
    check(err_stat == 1'b1, "R9 status held while idle", W'(err_stat), W'(1));
    run_frame(0, 1, '0, 64'h0F0F_F0F0_3C3C_C3C3, -1, 0);   // R9 cleared by start
    run_frame(1, 0, 64'h1122_3344_5566_7788, '0, 8, 0);    // R8 fault in strobe
    run_frame(0, 1, '0, 64'hFEDC_BA98_7654_3210, 7, 0);    // R8 fault in last slot
    run_frame(1, 0, 64'h0123_4567_89AB_CDEF, '0, -1, 1);   // R10 start while busy

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11 every frame gave done", W'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", W'(0), W'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule